// File: doc/BRIEF.md
# Multiplexed Grid Display Scanner with Key Matrix

This block drives a multiplexed vacuum-fluorescent style display. It steps through a programmable number of digit slots, from one to sixteen. In each slot it lights exactly one grid line and shows that digit's segment pattern, which it reads from a display memory through a synchronous read port. A three-bit brightness value sets how much of each slot the grid stays lit. The rest of the slot is blank, so the brightness changes in eighths.

After the last digit of each frame a key slot follows. In that slot the first twelve segment lines serve as key drive lines, one at a time. The eight return inputs are captured into a twelve-byte key image. The block raises a one-clock change pulse when the new image differs from the one before it. Eight output pins are shared. Each one carries either a high-numbered grid line or a high-numbered segment line, as its select bit chooses. While scanning is disabled, which is the case after reset, every display line stays low.

Top module: `grid_key_scanner`

## Requirements
- R1: While `scan_en` is low, including after reset, `grid_out`, `seg_out` and `shared_out` are all zero. Reset clears `key_data` and `key_chg`. When `scan_en` rises, the scan begins at digit 0, step 0.
- R2: A frame scans digits 0 through `digit_last` in ascending order. Each digit slot is 8 steps of `STEP_CYCLES` clocks. At most one grid line is lit at any time.
- R3: The grid of digit d is lit in steps 1 through `dim_level` of its slot. Step 0 and the steps above `dim_level` are blank. When `dim_level` is 0, no grid ever lights.
- R4: `ram_addr` carries the current digit index. The display memory answers one clock after the address. Its word is captured in the last clock of step 0 and shows on the segment lines from step 1 of the same slot. Bit j of `ram_data` is segment j, and segments 0 to 11 appear on `seg_out[11:0]`.
- R5: When `share_sel[i]` is 0, `shared_out[i]` carries grid line 8+i. When it is 1, the pin carries segment 19-i. Grid lines 0 to 7 appear on `grid_out[7:0]`.
- R6: After the last digit comes a key slot of 12 substeps of `STEP_CYCLES` clocks each. In substep k, only segment line k is high, all grids are off, and segments 12 to 19 are low. Digit 0 follows.
- R7: `key_ret` is captured in the last clock of key substep k into `key_data[8k+7:8k]`. That byte holds its value until the next capture of substep k.
- R8: `key_chg` pulses for exactly one clock, in the clock after the key slot ends, if any captured byte differs from its previous value. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Display scan enable; low forces all lines low and restarts the scan |
| digit_last | input | 4 | Index of the last digit scanned (0 to 15) |
| dim_level | input | 3 | Number of lit steps out of 8 per digit slot |
| share_sel | input | 8 | Per shared pin: 0 selects a grid line, 1 selects a segment line |
| ram_addr | output | 4 | Display memory read address (digit index) |
| ram_data | input | 20 | Display memory read word, one clock after the address |
| key_ret | input | 8 | Key matrix return lines |
| grid_out | output | 8 | Grid lines 0 to 7 |
| seg_out | output | 12 | Segment lines 0 to 11, also the key drive lines |
| shared_out | output | 8 | Shared pins, grid 8+i or segment 19-i |
| key_data | output | 96 | Key image, byte k for drive line k |
| key_chg | output | 1 | One-clock pulse when the key image changed |

## Verification
A slip in the step or digit counters shows within one step of `STEP_CYCLES` clocks: a grid lights on the wrong line, lights during the step 0 gap, or stays lit through the key slot. A fetch that comes too late or from the wrong address shows from step 1 onward as a segment pattern that belongs to another digit. A fault in the key capture or in the comparison logic shows only at the end of the frame, either as a wrong byte in `key_data` or as a change pulse that is missing, repeated or mistimed. For that reason the key scenarios run for several whole frames.

// File: rtl/gsk_pkg.sv
package gsk_pkg;

  typedef enum logic {
    PH_DIGIT = 1'b0,
    PH_KEY   = 1'b1
  } scan_phase_e;

  localparam int DIM_STEPS = 8;

  // A digit grid is lit in steps 1..dim of its 8-step slot.
  function automatic logic grid_lit(input int unsigned step, input int unsigned dim);
    return (step != 0) && (step <= dim);
  endfunction

endpackage

// File: rtl/gsk_timing.sv
module gsk_timing
  import gsk_pkg::*;
#(
  parameter int DIGITS_MAX  = 16,
  parameter int KEY_DRV     = 12,
  parameter int STEP_CYCLES = 4,
  localparam int DIG_W = $clog2(DIGITS_MAX),
  localparam int SUB_N = (KEY_DRV > DIM_STEPS) ? KEY_DRV : DIM_STEPS,
  localparam int SUB_W = $clog2(SUB_N),
  localparam int CYC_W = $clog2(STEP_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIG_W-1:0] digit_last,
  output scan_phase_e      phase,
  output logic [DIG_W-1:0] digit,
  output logic [SUB_W-1:0] sub,
  output logic             fetch_ev,
  output logic             key_sample_ev,
  output logic             frame_end_ev
);

  logic [CYC_W-1:0] cyc;
  logic step_end, dig_slot_end, key_last;

  assign step_end      = (cyc == CYC_W'(STEP_CYCLES - 1));
  assign dig_slot_end  = (phase == PH_DIGIT) && step_end && (sub == SUB_W'(DIM_STEPS - 1));
  assign key_last      = (phase == PH_KEY) && step_end && (sub == SUB_W'(KEY_DRV - 1));
  assign fetch_ev      = en && (phase == PH_DIGIT) && (sub == '0) && step_end;
  assign key_sample_ev = en && (phase == PH_KEY) && step_end;
  assign frame_end_ev  = en && key_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_DIGIT;
      digit <= '0;
      sub   <= '0;
      cyc   <= '0;
    end else if (!en) begin
      phase <= PH_DIGIT;
      digit <= '0;
      sub   <= '0;
      cyc   <= '0;
    end else if (!step_end) begin
      cyc <= cyc + 1'b1;
    end else begin
      cyc <= '0;
      if (phase == PH_DIGIT) begin
        if (dig_slot_end) begin
          sub <= '0;
          if (digit >= digit_last) phase <= PH_KEY;
          else                     digit <= digit + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end else if (key_last) begin
        sub   <= '0;
        digit <= '0;
        phase <= PH_DIGIT;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  AST_KEY_TO_DIGIT0: assert property (@(posedge clk) disable iff (!rst_n)
    key_last |=> (phase == PH_DIGIT && digit == '0 && sub == '0)); // R6

  AST_DIGIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dig_slot_end && digit < digit_last) |=> (digit == $past(digit) + 1'b1)); // R2

endmodule

// File: rtl/gsk_keyscan.sv
module gsk_keyscan #(
  parameter int KEY_DRV = 12,
  parameter int KEY_RET = 8,
  parameter int IDX_W   = 4,
  localparam int KEY_BITS = KEY_DRV * KEY_RET
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_ev,
  input  logic                last_ev,
  input  logic [IDX_W-1:0]    idx,
  input  logic [KEY_RET-1:0]  key_ret,
  output logic [KEY_BITS-1:0] key_data,
  output logic                key_chg
);

  logic [KEY_RET-1:0] kb [KEY_DRV];
  logic diff_acc;
  logic byte_diff;

  assign byte_diff = (kb[idx] != key_ret);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_DRV; i++) kb[i] <= '0;
      diff_acc <= 1'b0;
      key_chg  <= 1'b0;
    end else begin
      key_chg <= 1'b0;
      if (sample_ev) begin
        kb[idx] <= key_ret;
        if (last_ev) begin
          key_chg  <= diff_acc | byte_diff;
          diff_acc <= 1'b0;
        end else if (byte_diff) begin
          diff_acc <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < KEY_DRV; k++) begin : g_pack
    assign key_data[k*KEY_RET +: KEY_RET] = kb[k];
  end

  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_chg |=> !key_chg); // R8

  AST_CHG_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    key_chg |-> $past(last_ev)); // R8

  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_ev |=> $stable(key_data)); // R7

endmodule

// File: rtl/gsk_pinmux.sv
module gsk_pinmux #(
  parameter int DIGITS_MAX = 16,
  parameter int SEG_N      = 20,
  parameter int SHARE_N    = 8,
  localparam int DED_G = DIGITS_MAX - SHARE_N,
  localparam int DED_S = SEG_N - SHARE_N
) (
  input  logic [DIGITS_MAX-1:0] grid_vec,
  input  logic [SEG_N-1:0]      seg_vec,
  input  logic [SHARE_N-1:0]    share_sel,
  output logic [DED_G-1:0]      grid_out,
  output logic [DED_S-1:0]      seg_out,
  output logic [SHARE_N-1:0]    shared_out
);

  assign grid_out = grid_vec[DED_G-1:0];
  assign seg_out  = seg_vec[DED_S-1:0];

  // Shared pin i: high grid line DED_G+i, or segment line counted down from the top.
  for (genvar i = 0; i < SHARE_N; i++) begin : g_share
    assign shared_out[i] = share_sel[i] ? seg_vec[SEG_N-1-i] : grid_vec[DED_G+i];
  end

endmodule

// File: rtl/grid_key_scanner.sv
module grid_key_scanner
  import gsk_pkg::*;
#(
  parameter int DIGITS_MAX  = 16,
  parameter int SEG_N       = 20,
  parameter int SHARE_N     = 8,
  parameter int KEY_DRV     = 12,
  parameter int KEY_RET     = 8,
  parameter int STEP_CYCLES = 4,
  localparam int DIG_W    = $clog2(DIGITS_MAX),
  localparam int DIM_W    = $clog2(DIM_STEPS),
  localparam int DED_G    = DIGITS_MAX - SHARE_N,
  localparam int DED_S    = SEG_N - SHARE_N,
  localparam int KEY_BITS = KEY_DRV * KEY_RET,
  localparam int SUB_N    = (KEY_DRV > DIM_STEPS) ? KEY_DRV : DIM_STEPS,
  localparam int SUB_W    = $clog2(SUB_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en,
  input  logic [DIG_W-1:0]    digit_last,
  input  logic [DIM_W-1:0]    dim_level,
  input  logic [SHARE_N-1:0]  share_sel,
  output logic [DIG_W-1:0]    ram_addr,
  input  logic [SEG_N-1:0]    ram_data,
  input  logic [KEY_RET-1:0]  key_ret,
  output logic [DED_G-1:0]    grid_out,
  output logic [DED_S-1:0]    seg_out,
  output logic [SHARE_N-1:0]  shared_out,
  output logic [KEY_BITS-1:0] key_data,
  output logic                key_chg
);

  scan_phase_e      phase;
  logic [DIG_W-1:0] digit;
  logic [SUB_W-1:0] sub;
  logic             fetch_ev, key_sample_ev, frame_end_ev;
  logic [SEG_N-1:0]      seg_lat;
  logic [SEG_N-1:0]      seg_vec;
  logic [DIGITS_MAX-1:0] grid_vec;
  logic                  lit;

  gsk_timing #(
    .DIGITS_MAX (DIGITS_MAX),
    .KEY_DRV    (KEY_DRV),
    .STEP_CYCLES(STEP_CYCLES)
  ) u_timing (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (scan_en),
    .digit_last   (digit_last),
    .phase        (phase),
    .digit        (digit),
    .sub          (sub),
    .fetch_ev     (fetch_ev),
    .key_sample_ev(key_sample_ev),
    .frame_end_ev (frame_end_ev)
  );

  assign ram_addr = digit;

  // Segment word is latched at the end of the blank step 0, ahead of the lit steps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seg_lat <= '0;
    else if (fetch_ev) seg_lat <= ram_data;
  end

  assign lit = scan_en && (phase == PH_DIGIT) && grid_lit(int'(sub), int'(dim_level));

  always_comb begin
    grid_vec = '0;
    for (int j = 0; j < DIGITS_MAX; j++) grid_vec[j] = lit && (int'(digit) == j);
  end

  always_comb begin
    seg_vec = '0;
    if (scan_en) begin
      if (phase == PH_DIGIT) seg_vec = seg_lat;
      else for (int j = 0; j < KEY_DRV; j++) seg_vec[j] = (int'(sub) == j);
    end
  end

  gsk_pinmux #(
    .DIGITS_MAX(DIGITS_MAX),
    .SEG_N     (SEG_N),
    .SHARE_N   (SHARE_N)
  ) u_pinmux (
    .grid_vec  (grid_vec),
    .seg_vec   (seg_vec),
    .share_sel (share_sel),
    .grid_out  (grid_out),
    .seg_out   (seg_out),
    .shared_out(shared_out)
  );

  gsk_keyscan #(
    .KEY_DRV(KEY_DRV),
    .KEY_RET(KEY_RET),
    .IDX_W  (SUB_W)
  ) u_keyscan (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_ev(key_sample_ev),
    .last_ev  (frame_end_ev),
    .idx      (sub),
    .key_ret  (key_ret),
    .key_data (key_data),
    .key_chg  (key_chg)
  );

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (grid_out == '0 && seg_out == '0 && shared_out == '0)); // R1

  AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_vec)); // R2

  AST_BLANK_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DIGIT && sub == '0) |-> (grid_vec == '0)); // R3

  AST_KEY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && phase == PH_KEY) |-> (grid_vec == '0 && $countones(seg_vec) == 1)); // R6

endmodule

// File: tb/grid_key_scanner_bench.sv
`timescale 1ns/1ps
module grid_key_scanner_bench;

  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic [3:0]  digit_last = '0;
  logic [2:0]  dim_level = '0;
  logic [7:0]  share_sel = '0;
  logic [3:0]  ram_addr;
  logic [19:0] ram_data = '0;
  logic [7:0]  key_ret;
  logic [7:0]  grid_out;
  logic [11:0] seg_out;
  logic [7:0]  shared_out;
  logic [95:0] key_data;
  logic        key_chg;

  logic [19:0] mem [16];
  logic [7:0]  keys [12];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  grid_key_scanner u_grid_key_scanner (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .digit_last(digit_last),
    .dim_level(dim_level), .share_sel(share_sel), .ram_addr(ram_addr),
    .ram_data(ram_data), .key_ret(key_ret), .grid_out(grid_out),
    .seg_out(seg_out), .shared_out(shared_out), .key_data(key_data),
    .key_chg(key_chg)
  );

  // Display memory with a one-clock registered read.
  always_ff @(posedge clk) ram_data <= mem[ram_addr];

  // Key matrix: a pressed key joins its drive line to a return line.
  always_comb begin
    key_ret = '0;
    for (int k = 0; k < 12; k++) if (seg_out[k]) key_ret = key_ret | keys[k];
  end

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [95:0] key_image();
    logic [95:0] v;
    for (int k = 0; k < 12; k++) v[k*8 +: 8] = keys[k];
    return v;
  endfunction

  task automatic check_quiet(input string tag);
    chk(grid_out == '0 && seg_out == '0 && shared_out == '0, tag,
        {72'h0, grid_out, seg_out, shared_out}, 96'h0);
  endtask

  // Compare outputs against the scan position pos within a frame.
  task automatic check_pos(input int pos, input int dc, input int dim, input logic [7:0] sel);
    int slot, dlen, d, st, k;
    logic [15:0] eg;
    logic [19:0] es;
    logic [7:0]  esh, msk;
    bit known, keyph;
    slot = 8 * S;
    dlen = (dc + 1) * slot;
    eg = '0; es = '0; known = 1; keyph = 0;
    if (pos < dlen) begin
      d  = pos / slot;
      st = (pos % slot) / S;
      if (st >= 1 && st <= dim) eg[d] = 1'b1;
      known = (st >= 1);
      es = mem[d];
    end else begin
      keyph = 1;
      k = (pos - dlen) / S;
      es[k] = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin
      esh[i] = sel[i] ? es[19-i] : eg[8+i];
      msk[i] = known | ~sel[i];
    end
    chk(grid_out == eg[7:0], keyph ? "R6 grid off in key slot" : "R2 R3 grid line",
        {88'h0, grid_out}, {88'h0, eg[7:0]});
    if (known)
      chk(seg_out == es[11:0], keyph ? "R6 key drive" : "R4 segment word",
          {84'h0, seg_out}, {84'h0, es[11:0]});
    chk((shared_out & msk) == (esh & msk), keyph ? "R6 shared in key slot" : "R5 shared pins",
        {88'h0, shared_out & msk}, {88'h0, esh & msk});
  endtask

  task automatic scan_run(input int dc, input int dim, input logic [7:0] sel, input int frames);
    int fl;
    fl = (dc + 1) * 8 * S + 12 * S;
    @(negedge clk);
    scan_en = 1'b0; digit_last = dc[3:0]; dim_level = dim[2:0]; share_sel = sel;
    #1 check_quiet("R1 disabled lines low");
    @(negedge clk);
    scan_en = 1'b1;
    for (int n = 0; n < frames * fl; n++) begin
      #1;
      check_pos(n % fl, dc, dim, sel);
      if (key_chg) chk(0, "R8 no change pulse with idle keys", 96'h1, 96'h0);
      @(negedge clk);
    end
  endtask

  // Run ncyc cycles from scan position n0, counting key_chg pulses.
  task automatic count_pulses(input int n0, input int ncyc, input int fl, output int pulses);
    pulses = 0;
    for (int n = n0; n < n0 + ncyc; n++) begin
      #1;
      if (key_chg) begin
        pulses++;
        chk(n % fl == 0, "R8 pulse right after key slot", 96'(n % fl), 96'h0);
      end
      @(negedge clk);
    end
  endtask

  task automatic key_test();
    int fl, p;
    fl = 4 * 8 * S + 12 * S;
    for (int k = 0; k < 12; k++) keys[k] = 8'(1 << (k % 8)) ^ 8'(k * 3);
    @(negedge clk);
    scan_en = 1'b0; digit_last = 4'd3; dim_level = 3'd5; share_sel = 8'h00;
    @(negedge clk);
    scan_en = 1'b1;
    count_pulses(0, 2 * fl + 1, fl, p);
    chk(p == 1, "R8 one pulse for first image", 96'(p), 96'd1);
    chk(key_data == key_image(), "R7 key image captured", key_data, key_image());
    keys[5] = keys[5] ^ 8'h10;
    count_pulses(2 * fl + 1, fl, fl, p);
    chk(p == 1, "R8 pulse after single key change", 96'(p), 96'd1);
    chk(key_data == key_image(), "R7 changed byte captured", key_data, key_image());
    count_pulses(3 * fl + 1, fl, fl, p);
    chk(p == 0, "R8 no pulse when image unchanged", 96'(p), 96'd0);
    // Image must hold while the display stays off.
    @(negedge clk);
    scan_en = 1'b0;
    keys[0] = 8'hFF;
    repeat (20) @(negedge clk);
    #1 chk(key_data[7:0] == (8'(1) ^ 8'(0)), "R7 byte held without capture",
           {88'h0, key_data[7:0]}, 96'h1);
    check_quiet("R1 lines low after disable");
    for (int k = 0; k < 12; k++) keys[k] = '0;
  endtask

  task automatic mid_frame_restart();
    @(negedge clk);
    scan_en = 1'b0; digit_last = 4'd7; dim_level = 3'd4; share_sel = 8'h3C;
    @(negedge clk);
    scan_en = 1'b1;
    repeat (137) @(negedge clk);
    scan_run(7, 4, 8'h3C, 1);   // R1: restart at digit 0 step 0
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 20'((i + 1) * 32'h2D3A5) ^ 20'hF0F0F;
    for (int k = 0; k < 12; k++) keys[k] = '0;
    repeat (3) @(negedge clk);
    #1 check_quiet("R1 reset lines low");
    chk(key_data == '0 && key_chg == 1'b0, "R1 reset key state", {key_data[94:0], key_chg}, 96'h0);
    rst_n = 1'b1;
    scan_run(15, 7, 8'h00, 2);  // R2 all digits, R3 full dimmer
    scan_run(0, 3, 8'hFF, 2);   // R2 single digit, R5 all shared as segments
    scan_run(5, 0, 8'hA5, 1);   // R3 dim 0 dark
    scan_run(2, 1, 8'h5A, 2);   // R3 one lit step, R4 fetch
    mid_frame_restart();
    key_test();                 // R7 R8
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 scan did not finish act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule